// File: doc/BRIEF.md
# Bus-Side Local Memory Isolation Gate

This block sits between the shared system bus and the bus-facing port of a core's private local memory. The core's own memory port passes straight through it, whatever the lock state. When the isolation lock input is high, the gate checks every bus request against a single communication window. Requests that fall fully inside the window go through. Every other request is suppressed before it reaches the memory. A suppressed request is answered one cycle later with an error flag and all-zero read data.

The window is held in two configuration registers: a byte base and a byte size. Writes to these registers are taken only while the lock is low, so isolated software cannot have the window moved under it. No software-writable protection bit is involved. Protection follows the lock signal alone.

The same gate controls a root-key decrypt facility. A key request is granted only when it comes from the local core while the lock is high. The words produced by the decrypt datapath are forwarded to memory only while the lock is high, and only when they land outside the communication window, so unsealed secrets never appear in bus-visible memory.

Top module: `lmem_iso_gate`

## Requirements
- R1: The core-side signals (enable, write, word address, byte enables, write data) appear unchanged on the core memory port in the same cycle, and `core_rdata` equals `mem_c_rdata`, regardless of `iso_lock`.
- R2: With `iso_lock` low, every bus request is forwarded in the same cycle. The access covers 2^`bus_sz` bytes starting at `bus_addr` aligned down to that size. `mem_b_addr` is the start byte address divided by the word byte count. `mem_b_be` has a bit set for each covered byte lane. One cycle later `bus_done`=1 and `bus_err`=0. For a read, `bus_rdata` equals `mem_b_rdata`; for a write it is 0.
- R3: With `iso_lock` high, an access whose bytes all lie in [base, base+size) is handled exactly as in R2.
- R4: With `iso_lock` high, an access with no byte in the window does not raise `mem_b_en`. One cycle later `bus_done`=1, `bus_err`=1 and `bus_rdata`=0, for reads and writes alike.
- R5: With `iso_lock` high, an access that has bytes both inside and outside the window is blocked completely, as in R4.
- R6: A window size of 0 means there is no window. While locked, every bus access is blocked, and a decrypt write to any address is accepted.
- R7: A configuration write (`cfg_we`) is captured at a clock edge only when `iso_lock` is low, and takes effect from the next cycle. While `iso_lock` is high it is ignored.
- R8: `key_grant` rises one cycle after a `key_req` with `key_from_core`=1 and `iso_lock`=1. Any other `key_req` raises `key_deny` one cycle later. With no request, both are 0.
- R9: A decrypt write (`dec_we`) is forwarded to the key write port in the same cycle only when `iso_lock` is high and its word (bytes `dec_addr`*8 to `dec_addr`*8+7) shares no byte with the window. Otherwise nothing is written and `dec_reject` rises one cycle later.
- R10: After reset, the window base is `WIN_BASE_RST` and the window size is `WIN_SIZE_RST`. `bus_done`, `bus_err`, `bus_rdata`, `key_grant`, `key_deny` and `dec_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iso_lock | input | 1 | Isolation lock from the core's control logic |
| cfg_we | input | 1 | Window register write strobe |
| cfg_base | input | ADDR_W | New window base, in bytes |
| cfg_size | input | ADDR_W+1 | New window size, in bytes |
| core_en | input | 1 | Core access enable |
| core_we | input | 1 | Core write |
| core_addr | input | ADDR_W-3 | Core word address |
| core_be | input | DATA_W/8 | Core byte enables |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Core read data |
| mem_c_en | output | 1 | Memory core-port enable |
| mem_c_we | output | 1 | Memory core-port write |
| mem_c_addr | output | ADDR_W-3 | Memory core-port word address |
| mem_c_be | output | DATA_W/8 | Memory core-port byte enables |
| mem_c_wdata | output | DATA_W | Memory core-port write data |
| mem_c_rdata | input | DATA_W | Memory core-port read data |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | Bus write |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_sz | input | 2 | Log2 of the access size in bytes |
| bus_wdata | input | DATA_W | Bus write data, lane-aligned |
| bus_done | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Response marks a blocked access |
| bus_rdata | output | DATA_W | Bus read data (zero unless a permitted read) |
| mem_b_en | output | 1 | Memory bus-port enable |
| mem_b_we | output | 1 | Memory bus-port write |
| mem_b_addr | output | ADDR_W-3 | Memory bus-port word address |
| mem_b_be | output | DATA_W/8 | Memory bus-port byte enables |
| mem_b_wdata | output | DATA_W | Memory bus-port write data |
| mem_b_rdata | input | DATA_W | Memory bus-port read data, one cycle after enable |
| key_req | input | 1 | Root-key decrypt request |
| key_from_core | input | 1 | Request comes from the local core |
| key_grant | output | 1 | Request granted |
| key_deny | output | 1 | Request refused |
| dec_we | input | 1 | Decrypted word write strobe |
| dec_addr | input | ADDR_W-3 | Decrypted word address |
| dec_wdata | input | DATA_W | Decrypted word |
| dec_reject | output | 1 | Decrypted word was discarded |
| mem_k_we | output | 1 | Key write port strobe to memory |
| mem_k_addr | output | ADDR_W-3 | Key write port word address |
| mem_k_wdata | output | DATA_W | Key write port data |

## Verification
A window register that was corrupted, or that changed while locked, shows up on the first bus access near the window edge. That access either reaches `mem_b_en` when it should not, or comes back with `bus_err` one cycle later, so each access pattern probes the stored window within two cycles. A stale or wrong access-type flag in the response stage appears on the very next `bus_done` as leaked or zeroed read data. A lock sampled at the wrong cycle shows as an inconsistent grant, deny or reject strobe one cycle after the request.

// File: rtl/lmig_pkg.sv
package lmig_pkg;

  // True when the byte range [s, s+n) lies wholly in [b, b+z); an empty window holds nothing.
  function automatic logic range_inside(input longint unsigned s, input longint unsigned n,
                                        input longint unsigned b, input longint unsigned z);
    return (z != 0) && (s >= b) && ((s + n) <= (b + z));
  endfunction

  // True when the byte range [s, s+n) shares no byte with [b, b+z).
  function automatic logic range_clear(input longint unsigned s, input longint unsigned n,
                                       input longint unsigned b, input longint unsigned z);
    return (z == 0) || ((s + n) <= b) || (s >= (b + z));
  endfunction

  // Byte-lane mask: nbytes consecutive lanes starting at lane off.
  function automatic logic [63:0] lane_mask(input int unsigned off, input int unsigned nbytes);
    logic [63:0] ones;
    ones = (nbytes >= 64) ? {64{1'b1}} : ((64'd1 << nbytes) - 64'd1);
    return ones << off;
  endfunction

endpackage

// File: rtl/lmig_win_regs.sv
module lmig_win_regs #(
  parameter int ADDR_W       = 16,
  parameter int WIN_BASE_RST = 0,
  parameter int WIN_SIZE_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iso_lock,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W:0]   cfg_size,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W:0]   win_size,
  output logic              cfg_take
);

  // Window may only move while the core is not isolated.
  assign cfg_take = cfg_we & ~iso_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_base <= ADDR_W'(WIN_BASE_RST);
      win_size <= (ADDR_W+1)'(WIN_SIZE_RST);
    end else if (cfg_take) begin
      win_base <= cfg_base;
      win_size <= cfg_size;
    end
  end

endmodule

// File: rtl/lmig_bus_filter.sv
module lmig_bus_filter
  import lmig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int SZ_W   = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  iso_lock,
  input  logic [ADDR_W-1:0]                     win_base,
  input  logic [ADDR_W:0]                       win_size,
  input  logic                                  bus_req,
  input  logic                                  bus_we,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic [SZ_W-1:0]                       bus_sz,
  input  logic [DATA_W-1:0]                     bus_wdata,
  output logic                                  bus_done,
  output logic                                  bus_err,
  output logic [DATA_W-1:0]                     bus_rdata,
  output logic                                  mem_b_en,
  output logic                                  mem_b_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_b_addr,
  output logic [DATA_W/8-1:0]                   mem_b_be,
  output logic [DATA_W-1:0]                     mem_b_wdata,
  input  logic [DATA_W-1:0]                     mem_b_rdata,
  output logic                                  win_hit,
  output logic                                  acc_block
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [ADDR_W:0]   acc_len;
  logic [ADDR_W-1:0] acc_start;
  logic              acc_pass;
  logic              done_q, err_q, rd_q;

  // Access footprint: 2^sz bytes, start aligned down to the access size.
  assign acc_len   = (ADDR_W+1)'(1) << bus_sz;
  assign acc_start = bus_addr & ~(acc_len[ADDR_W-1:0] - ADDR_W'(1));

  assign win_hit   = range_inside(64'(acc_start), 64'(acc_len), 64'(win_base), 64'(win_size));
  assign acc_pass  = bus_req & (~iso_lock | win_hit);
  assign acc_block = bus_req & iso_lock & ~win_hit;

  assign mem_b_en    = acc_pass;
  assign mem_b_we    = acc_pass & bus_we;
  assign mem_b_addr  = acc_start[ADDR_W-1:OFF_W];
  assign mem_b_be    = BYTES'(lane_mask(32'(acc_start[OFF_W-1:0]), 32'(acc_len)));
  assign mem_b_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      done_q <= bus_req;
      err_q  <= acc_block;
      rd_q   <= acc_pass & ~bus_we;
    end
  end

  assign bus_done  = done_q;
  assign bus_err   = err_q;
  assign bus_rdata = rd_q ? mem_b_rdata : '0;

endmodule

// File: rtl/lmig_key_gate.sv
module lmig_key_gate
  import lmig_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               iso_lock,
  input  logic [ADDR_W-1:0]                  win_base,
  input  logic [ADDR_W:0]                    win_size,
  input  logic                               key_req,
  input  logic                               key_from_core,
  output logic                               key_grant,
  output logic                               key_deny,
  input  logic                               dec_we,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] dec_addr,
  input  logic [DATA_W-1:0]                  dec_wdata,
  output logic                               dec_reject,
  output logic                               mem_k_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_k_addr,
  output logic [DATA_W-1:0]                  mem_k_wdata,
  output logic                               key_ok,
  output logic                               dec_ok
);

  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [ADDR_W-1:0] dec_start;
  logic              dec_clear;
  logic              grant_q, deny_q, rej_q;

  assign key_ok    = key_req & key_from_core & iso_lock;
  assign dec_start = {dec_addr, {OFF_W{1'b0}}};
  assign dec_clear = range_clear(64'(dec_start), 64'(BYTES), 64'(win_base), 64'(win_size));
  assign dec_ok    = dec_we & iso_lock & dec_clear;

  assign mem_k_we    = dec_ok;
  assign mem_k_addr  = dec_addr;
  assign mem_k_wdata = dec_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      grant_q <= key_ok;
      deny_q  <= key_req & ~key_ok;
      rej_q   <= dec_we & ~dec_ok;
    end
  end

  assign key_grant  = grant_q;
  assign key_deny   = deny_q;
  assign dec_reject = rej_q;

endmodule

// File: rtl/lmem_iso_gate.sv
module lmem_iso_gate #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 64,
  parameter int WIN_BASE_RST = 0,
  parameter int WIN_SIZE_RST = 0,
  parameter int SZ_W         = $clog2($clog2(DATA_W/8) + 1)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               iso_lock,
  input  logic                               cfg_we,
  input  logic [ADDR_W-1:0]                  cfg_base,
  input  logic [ADDR_W:0]                    cfg_size,
  input  logic                               core_en,
  input  logic                               core_we,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] core_addr,
  input  logic [DATA_W/8-1:0]                core_be,
  input  logic [DATA_W-1:0]                  core_wdata,
  output logic [DATA_W-1:0]                  core_rdata,
  output logic                               mem_c_en,
  output logic                               mem_c_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_c_addr,
  output logic [DATA_W/8-1:0]                mem_c_be,
  output logic [DATA_W-1:0]                  mem_c_wdata,
  input  logic [DATA_W-1:0]                  mem_c_rdata,
  input  logic                               bus_req,
  input  logic                               bus_we,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [SZ_W-1:0]                    bus_sz,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic                               bus_done,
  output logic                               bus_err,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic                               mem_b_en,
  output logic                               mem_b_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_b_addr,
  output logic [DATA_W/8-1:0]                mem_b_be,
  output logic [DATA_W-1:0]                  mem_b_wdata,
  input  logic [DATA_W-1:0]                  mem_b_rdata,
  input  logic                               key_req,
  input  logic                               key_from_core,
  output logic                               key_grant,
  output logic                               key_deny,
  input  logic                               dec_we,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] dec_addr,
  input  logic [DATA_W-1:0]                  dec_wdata,
  output logic                               dec_reject,
  output logic                               mem_k_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_k_addr,
  output logic [DATA_W-1:0]                  mem_k_wdata
);

  // Named internal events, observed by the bound checker.
  logic [ADDR_W-1:0] win_base_q;
  logic [ADDR_W:0]   win_size_q;
  logic              cfg_take;
  logic              win_hit;
  logic              acc_block;
  logic              key_ok;
  logic              dec_ok;

  // Core side: untouched by the isolation state.
  assign mem_c_en    = core_en;
  assign mem_c_we    = core_we;
  assign mem_c_addr  = core_addr;
  assign mem_c_be    = core_be;
  assign mem_c_wdata = core_wdata;
  assign core_rdata  = mem_c_rdata;

  lmig_win_regs #(
    .ADDR_W      (ADDR_W),
    .WIN_BASE_RST(WIN_BASE_RST),
    .WIN_SIZE_RST(WIN_SIZE_RST)
  ) win_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .iso_lock(iso_lock),
    .cfg_we  (cfg_we),
    .cfg_base(cfg_base),
    .cfg_size(cfg_size),
    .win_base(win_base_q),
    .win_size(win_size_q),
    .cfg_take(cfg_take)
  );

  lmig_bus_filter #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SZ_W  (SZ_W)
  ) filt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_lock   (iso_lock),
    .win_base   (win_base_q),
    .win_size   (win_size_q),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_sz     (bus_sz),
    .bus_wdata  (bus_wdata),
    .bus_done   (bus_done),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .mem_b_en   (mem_b_en),
    .mem_b_we   (mem_b_we),
    .mem_b_addr (mem_b_addr),
    .mem_b_be   (mem_b_be),
    .mem_b_wdata(mem_b_wdata),
    .mem_b_rdata(mem_b_rdata),
    .win_hit    (win_hit),
    .acc_block  (acc_block)
  );

  lmig_key_gate #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) key_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .iso_lock     (iso_lock),
    .win_base     (win_base_q),
    .win_size     (win_size_q),
    .key_req      (key_req),
    .key_from_core(key_from_core),
    .key_grant    (key_grant),
    .key_deny     (key_deny),
    .dec_we       (dec_we),
    .dec_addr     (dec_addr),
    .dec_wdata    (dec_wdata),
    .dec_reject   (dec_reject),
    .mem_k_we     (mem_k_we),
    .mem_k_addr   (mem_k_addr),
    .mem_k_wdata  (mem_k_wdata),
    .key_ok       (key_ok),
    .dec_ok       (dec_ok)
  );

endmodule

// File: rtl/lmig_chk.sv
module lmig_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iso_lock,
  input logic              bus_req,
  input logic              bus_done,
  input logic              bus_err,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              mem_b_en,
  input logic              win_hit,
  input logic [ADDR_W-1:0] win_base,
  input logic [ADDR_W:0]   win_size,
  input logic              key_req,
  input logic              key_from_core,
  input logic              key_grant,
  input logic              key_deny,
  input logic              dec_we,
  input logic              mem_k_we,
  input logic              dec_reject
);

  // R2: open bus while unlocked, answered without error.
  a_r2_open_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (!iso_lock && bus_req) |=> (bus_done && !bus_err));

  // R4 / R5: outside or straddling accesses never reach memory.
  a_r4_no_mem_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_lock && bus_req && !win_hit) |-> !mem_b_en);

  // R4: blocked access answered with the error flag next cycle.
  a_r4_err_next: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_lock && bus_req && !win_hit) |=> (bus_done && bus_err));

  // R4: an error response carries no data.
  a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R3: in-window accesses under lock go to memory.
  a_r3_win_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_lock && bus_req && win_hit) |-> mem_b_en);

  // R7: window frozen across a locked cycle.
  a_r7_win_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    iso_lock |=> ($stable(win_base) && $stable(win_size)));

  // R8: grant only for a locked request from the core.
  a_r8_grant_src: assert property (@(posedge clk) disable iff (!rst_n)
    key_grant |-> ($past(key_req) && $past(key_from_core) && $past(iso_lock)));

  // R8: grant and deny are exclusive.
  a_r8_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_grant, key_deny}));

  // R9: decrypted data only reaches memory under lock.
  a_r9_dec_locked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_k_we |-> (iso_lock && dec_we));

  // R9: a discarded word was never written.
  a_r9_rej_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dec_reject |-> ($past(dec_we) && !$past(mem_k_we)));

endmodule

bind lmem_iso_gate lmig_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .iso_lock     (iso_lock),
  .bus_req      (bus_req),
  .bus_done     (bus_done),
  .bus_err      (bus_err),
  .bus_rdata    (bus_rdata),
  .mem_b_en     (mem_b_en),
  .win_hit      (win_hit),
  .win_base     (win_base_q),
  .win_size     (win_size_q),
  .key_req      (key_req),
  .key_from_core(key_from_core),
  .key_grant    (key_grant),
  .key_deny     (key_deny),
  .dec_we       (dec_we),
  .mem_k_we     (mem_k_we),
  .dec_reject   (dec_reject)
);

// File: tb/lmem_iso_gate_tb.sv
module lmem_iso_gate_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int BYTES  = 8;
  localparam int WA_W   = 13;
  localparam int RBASE  = 'h200;
  localparam int RSIZE  = 'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              iso_lock = 0, cfg_we = 0;
  logic [ADDR_W-1:0] cfg_base = 0;
  logic [ADDR_W:0]   cfg_size = 0;
  logic              core_en = 0, core_we = 0;
  logic [WA_W-1:0]   core_addr = 0;
  logic [BYTES-1:0]  core_be = 0;
  logic [DATA_W-1:0] core_wdata = 0, core_rdata, mem_c_rdata;
  logic              mem_c_en, mem_c_we;
  logic [WA_W-1:0]   mem_c_addr;
  logic [BYTES-1:0]  mem_c_be;
  logic [DATA_W-1:0] mem_c_wdata;
  logic              bus_req = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = 0;
  logic [1:0]        bus_sz = 0;
  logic [DATA_W-1:0] bus_wdata = 0, bus_rdata, mem_b_wdata, mem_b_rdata;
  logic              bus_done, bus_err, mem_b_en, mem_b_we;
  logic [WA_W-1:0]   mem_b_addr;
  logic [BYTES-1:0]  mem_b_be;
  logic              key_req = 0, key_from_core = 0, key_grant, key_deny;
  logic              dec_we = 0;
  logic [WA_W-1:0]   dec_addr = 0;
  logic [DATA_W-1:0] dec_wdata = 0, mem_k_wdata;
  logic              dec_reject, mem_k_we;
  logic [WA_W-1:0]   mem_k_addr;

  lmem_iso_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE_RST(RBASE), .WIN_SIZE_RST(RSIZE)) dut_i (
    .clk(clk), .rst_n(rst_n), .iso_lock(iso_lock), .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .core_en(core_en), .core_we(core_we), .core_addr(core_addr), .core_be(core_be), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .mem_c_en(mem_c_en), .mem_c_we(mem_c_we), .mem_c_addr(mem_c_addr),
    .mem_c_be(mem_c_be), .mem_c_wdata(mem_c_wdata), .mem_c_rdata(mem_c_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_sz(bus_sz), .bus_wdata(bus_wdata),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata), .mem_b_en(mem_b_en), .mem_b_we(mem_b_we),
    .mem_b_addr(mem_b_addr), .mem_b_be(mem_b_be), .mem_b_wdata(mem_b_wdata), .mem_b_rdata(mem_b_rdata),
    .key_req(key_req), .key_from_core(key_from_core), .key_grant(key_grant), .key_deny(key_deny),
    .dec_we(dec_we), .dec_addr(dec_addr), .dec_wdata(dec_wdata), .dec_reject(dec_reject),
    .mem_k_we(mem_k_we), .mem_k_addr(mem_k_addr), .mem_k_wdata(mem_k_wdata));

  int total = 0, bad = 0;
  bit chk_on = 0;
  string cur_tag = "";

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural memory behind the bus port; core port returns an address-derived pattern.
  logic [63:0] mem_m [int];
  logic [63:0] b_rd_q = '0;
  assign mem_b_rdata = b_rd_q;
  assign mem_c_rdata = {51'h0, mem_c_addr} ^ 64'hC3C3_0F0F_5A5A_9696;

  function automatic bit m_inside(longint s, longint n, longint b, longint z);
    return z != 0 && s >= b && s + n <= b + z;
  endfunction
  function automatic bit m_touch(longint s, longint n, longint b, longint z);
    return z != 0 && s < b + z && s + n > b;
  endfunction

  // Reference model state.
  longint m_base = RBASE, m_size = RSIZE;
  bit     e_done, e_err, e_rd, e_grant, e_deny, e_rej;
  string  e_tag = "R10", last_tag = "R2";

  function automatic string tag_now();
    longint n, s;
    n = longint'(1) << bus_sz;
    s = longint'(bus_addr) - (longint'(bus_addr) % n);
    if (cur_tag != "") return cur_tag;
    if (!iso_lock) return "R2";
    if (m_size == 0) return "R6";
    if (m_inside(s, n, m_base, m_size)) return "R3";
    if (m_touch(s, n, m_base, m_size)) return "R5";
    return "R4";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = RBASE; m_size = RSIZE;
      e_done = 0; e_err = 0; e_rd = 0; e_grant = 0; e_deny = 0; e_rej = 0;
    end else begin
      longint n, s;
      bit in_w, k_ok, d_ok;
      n = longint'(1) << bus_sz;
      s = longint'(bus_addr) - (longint'(bus_addr) % n);
      in_w = m_inside(s, n, m_base, m_size);
      if (bus_req && (!iso_lock || in_w)) begin
        if (bus_we) begin
          logic [63:0] w;
          w = mem_m.exists(int'(s / 8)) ? mem_m[int'(s / 8)] : 64'h0;
          for (int i = 0; i < 8; i++)
            if (i >= s % 8 && i < s % 8 + n) w[i*8 +: 8] = bus_wdata[i*8 +: 8];
          mem_m[int'(s / 8)] = w;
        end else begin
          b_rd_q <= mem_m.exists(int'(s / 8)) ? mem_m[int'(s / 8)] : 64'h0;
        end
      end
      e_tag  = tag_now();
      e_done = bus_req;
      e_err  = bus_req && iso_lock && !in_w;
      e_rd   = bus_req && !bus_we && (!iso_lock || in_w);
      k_ok   = key_req && key_from_core && iso_lock;
      e_grant = k_ok;
      e_deny  = key_req && !k_ok;
      d_ok   = dec_we && iso_lock && !m_touch(longint'(dec_addr) * 8, 8, m_base, m_size);
      e_rej  = dec_we && !d_ok;
      if (cfg_we && !iso_lock) begin
        m_base = longint'(cfg_base);
        m_size = longint'(cfg_size);
      end
    end
  end

  // Compare every cycle, well after the falling edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && chk_on) begin
      longint n, s;
      bit in_w, exp_en, exp_k;
      logic [7:0] exp_be;
      string t;
      n = longint'(1) << bus_sz;
      s = longint'(bus_addr) - (longint'(bus_addr) % n);
      in_w = m_inside(s, n, m_base, m_size);
      t = tag_now();
      exp_en = bus_req && (!iso_lock || in_w);
      chk(t, "mem_b_en", 128'(mem_b_en), 128'(exp_en));
      if (exp_en) begin
        exp_be = '0;
        for (int i = 0; i < 8; i++) if (i >= s % 8 && i < s % 8 + n) exp_be[i] = 1'b1;
        chk(t, "mem_b_addr", 128'(mem_b_addr), 128'(s / 8));
        chk(t, "mem_b_be", 128'(mem_b_be), 128'(exp_be));
        chk(t, "mem_b_we", 128'(mem_b_we), 128'(bus_we));
        chk(t, "mem_b_wdata", 128'(mem_b_wdata), 128'(bus_wdata));
      end
      chk(e_tag, "bus_done", 128'(bus_done), 128'(e_done));
      chk(e_tag, "bus_err", 128'(bus_err), 128'(e_err));
      chk(e_tag, "bus_rdata", 128'(bus_rdata), e_rd ? 128'(b_rd_q) : 128'(0));
      chk("R1", "core port", {mem_c_en, mem_c_we, mem_c_addr, mem_c_be, mem_c_wdata},
          {core_en, core_we, core_addr, core_be, core_wdata});
      chk("R1", "core_rdata", 128'(core_rdata), 128'({51'h0, core_addr} ^ 64'hC3C3_0F0F_5A5A_9696));
      chk("R8", "key_grant", 128'(key_grant), 128'(e_grant));
      chk("R8", "key_deny", 128'(key_deny), 128'(e_deny));
      exp_k = dec_we && iso_lock && !m_touch(longint'(dec_addr) * 8, 8, m_base, m_size);
      chk(m_size == 0 ? "R6" : "R9", "mem_k_we", 128'(mem_k_we), 128'(exp_k));
      if (exp_k) chk("R9", "mem_k data", {mem_k_addr, mem_k_wdata}, {dec_addr, dec_wdata});
      chk("R9", "dec_reject", 128'(dec_reject), 128'(e_rej));
    end
  end

  // Core side keeps moving throughout, independent of the lock.
  always @(negedge clk) begin
    core_en    = 1'($urandom);
    core_we    = 1'($urandom);
    core_addr  = WA_W'($urandom);
    core_be    = BYTES'($urandom);
    core_wdata = {$urandom, $urandom};
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    bus_req = 0; bus_we = 0; cfg_we = 0; key_req = 0; dec_we = 0;
  endtask

  task automatic bus_op(bit we, int addr, int sz, logic [63:0] d);
    quiet();
    bus_req = 1; bus_we = we; bus_addr = ADDR_W'(addr); bus_sz = 2'(sz); bus_wdata = d;
    step();
    quiet();
  endtask

  task automatic cfg(int b, int z);
    quiet();
    cfg_we = 1; cfg_base = ADDR_W'(b); cfg_size = (ADDR_W+1)'(z);
    step();
    quiet();
  endtask

  task automatic key(bit core);
    quiet();
    key_req = 1; key_from_core = core;
    step();
    quiet();
  endtask

  task automatic dec(int wa, logic [63:0] d);
    quiet();
    dec_we = 1; dec_addr = WA_W'(wa); dec_wdata = d;
    step();
    quiet();
  endtask

  bit wd_hit = 0;
  initial begin
    #(8 * 200000);
    wd_hit = 1;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    // R10: registered outputs idle during reset.
    chk("R10", "reset outputs", {bus_done, bus_err, key_grant, key_deny, dec_reject}, 128'(0));
    chk("R10", "reset rdata", 128'(bus_rdata), 128'(0));
    rst_n = 1;
    step();
    chk_on = 1;
    // R10: reset window [0x200,0x220) honoured under lock.
    cur_tag = "R10";
    iso_lock = 1;
    bus_op(0, 'h200, 3, 0);
    bus_op(0, 'h220, 3, 0);
    bus_op(1, 'h218, 3, 64'h1111);
    step();
    cur_tag = "";
    iso_lock = 0;
    step();
    // R2: open access, several sizes.
    cfg('h104, 'h40);
    bus_op(1, 'h100, 3, 64'h0123_4567_89AB_CDEF);
    bus_op(1, 'h10C, 2, 64'hDEAD_BEEF_0000_0000);
    bus_op(1, 'h181, 0, 64'h0000_0000_0000_7700);
    bus_op(0, 'h100, 3, 0);
    bus_op(0, 'h108, 3, 0);
    bus_op(0, 'h180, 1, 0);
    // Locked: window [0x104,0x144).
    iso_lock = 1;
    step();
    bus_op(1, 'h108, 3, 64'hAAAA_BBBB_CCCC_DDDD); // R3
    bus_op(0, 'h108, 3, 0);                       // R3
    bus_op(0, 'h100, 3, 0);                       // R5 straddle low edge
    bus_op(1, 'h140, 3, 64'hFFFF);                // R5 straddle high edge
    bus_op(0, 'h104, 2, 0);                       // R3 exact base
    bus_op(0, 'h142, 1, 0);                       // R3 touching end
    bus_op(0, 'h144, 0, 0);                       // R4 first byte past end
    bus_op(1, 'h181, 0, 64'h0000_0000_0000_1100); // R4 blocked write
    bus_op(0, 'h0, 3, 0);                         // R4
    // R8
    key(1); key(0); step();
    // R9
    dec('h10, 64'h5EC0_0001);
    dec('h20, 64'h5EC0_0002);
    dec('h28, 64'h5EC0_0003);
    dec('h29, 64'h5EC0_0004);
    // R7: config ignored while locked.
    cur_tag = "R7";
    cfg('h300, 'h10);
    bus_op(0, 'h300, 3, 0);
    bus_op(0, 'h110, 3, 0);
    cur_tag = "";
    iso_lock = 0;
    step();
    key(1); dec('h10, 64'h1); // unlocked: R8 deny, R9 reject
    bus_op(0, 'h180, 3, 0);   // blocked byte write left no trace
    bus_op(0, 'h140, 3, 0);
    // R6: empty window.
    cfg('h104, 0);
    iso_lock = 1;
    step();
    cur_tag = "R6";
    bus_op(0, 'h104, 0, 0);
    bus_op(1, 'h108, 3, 64'h9);
    dec('h20, 64'h77);
    cur_tag = "";
    iso_lock = 0;
    step();
    // Mixed traffic with lock toggling.
    for (int c = 0; c < 1500; c++) begin
      if ($urandom % 20 == 0) iso_lock = ~iso_lock;
      cfg_we = ($urandom % 10 == 0);
      cfg_base = ADDR_W'($urandom % 'h400);
      cfg_size = (ADDR_W+1)'($urandom % 'h100);
      bus_req = 1'($urandom); bus_we = 1'($urandom);
      bus_addr = ADDR_W'($urandom % 'h500); bus_sz = 2'($urandom);
      bus_wdata = {$urandom, $urandom};
      key_req = 1'($urandom); key_from_core = 1'($urandom);
      dec_we = 1'($urandom); dec_addr = WA_W'($urandom % 'hA0); dec_wdata = {$urandom, $urandom};
      step();
    end
    quiet();
    step(); step();
    if (!wd_hit) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule